// File: doc/BRIEF.md
# Barrel Shift Unit for an ALU

This block is the shift section of a small processor ALU. It takes a 32-bit operand, a 5-bit shift count and a 2-bit operation select, and returns a 32-bit result. It can shift left with zero fill, shift right with zero fill, or shift right while copying the operand's sign bit into the vacated positions. The one unused select code returns the operand unchanged.

The unit has no clock, no reset and no stored state. The result is a pure function of the present inputs, so it can sit in the same cycle as the rest of the ALU datapath. Inside, one log-depth right-shift network does all three shifts. A left shift reverses the operand's bit order on the way in and again on the way out. The fill bit is chosen once, as zero or as operand bit 31.

The only state-like element is the decode of the operation select. It is an enumeration with four named values: SHL_ZERO (00), PASS (01), SHR_ZERO (10) and SHR_SIGN (11). There are no states and no transitions between them. Each code maps straight to one datapath setting.

Top module: `alu_shift_unit`

## Requirements
- R1: When the shift count is 0, the result equals the operand for every select code.
- R2: Select 00 shifts the operand left by the count and fills the vacated low bits with 0. For example, 0xFEDCBA98 shifted by 4 gives 0xEDCBA980.
- R3: Select 10 shifts the operand right by the count and fills the vacated high bits with 0. For example, 0xFEDCBA98 shifted by 24 gives 0x000000FE.
- R4: Select 11 shifts the operand right by the count and copies operand bit 31 into every vacated high bit. For example, 0xFEDCBA98 gives 0xFFFFFEDC for a count of 16 and 0xFFFFFFFF for a count of 31.
- R5: When operand bit 31 is 0, select 11 and select 10 give identical results for every count.
- R6: Select 01 returns the operand unchanged, whatever the count.
- R7: The result follows the inputs with no clock. A new input value shows on the result in the same time step, with no edge needed.
- R8: For both a negative and a positive operand, every count from 0 to 31 gives the mathematically shifted value for each of the three shift selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | Operand to be shifted |
| sh_cnt | input | 5 | Unsigned shift count, 0 to 31 |
| op_sel | input | 2 | 00 shift left, 01 pass, 10 shift right zero fill, 11 shift right sign fill |
| result | output | 32 | Shifted operand |

## Verification
The bench targets these corner cases:
- **Count of zero under every select.** A network that enables a stage when its count bit is clear would corrupt the operand here.
- **Count of 31.** A stage with the wrong distance or a dropped top stage shows up here as a wrong single surviving bit.
- **Right shifts of a positive operand.** A sign-fill path that fills with 1 regardless of bit 31 would diverge from the zero-fill shift.
- **The unused select code 01 with a nonzero count.** A decoder that falls into one of the shifts would return a shifted value instead of the operand.
- **Left shift.** A wrong bit-reversal wiring would scramble the result, and a reversal left in place would give a right shift where a left shift is expected.

// File: rtl/alu_shift_pkg.sv
package alu_shift_pkg;

    typedef enum logic [1:0] {
        SHL_ZERO = 2'b00,
        PASS     = 2'b01,
        SHR_ZERO = 2'b10,
        SHR_SIGN = 2'b11
    } shift_op_e;

endpackage

// File: rtl/alu_shift_bitrev.sv
module alu_shift_bitrev #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign dout[i] = din[W-1-i];
    end

endmodule

// File: rtl/alu_shift_stage.sv
module alu_shift_stage #(
    parameter int W    = 32,
    parameter int DIST = 1
) (
    input  logic [W-1:0] din,
    input  logic         fill,
    input  logic         en,
    output logic [W-1:0] dout
);

    logic [W-1:0] moved;

    assign moved = {{DIST{fill}}, din[W-1:DIST]};
    assign dout  = en ? moved : din;

endmodule

// File: rtl/alu_shift_barrel.sv
module alu_shift_barrel #(
    parameter int W     = 32,
    parameter int CNT_W = 5
) (
    input  logic [W-1:0]     din,
    input  logic [CNT_W-1:0] cnt,
    input  logic             fill,
    output logic [W-1:0]     dout
);

    logic [W-1:0] lvl [0:CNT_W];

    assign lvl[0] = din;

    for (genvar k = 0; k < CNT_W; k++) begin : g_stage
        alu_shift_stage #(
            .W    (W),
            .DIST (1 << k)
        ) u_stage (
            .din  (lvl[k]),
            .fill (fill),
            .en   (cnt[k]),
            .dout (lvl[k+1])
        );
    end

    assign dout = lvl[CNT_W];

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import alu_shift_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         opnd_a,
    input  logic [$clog2(DATA_W)-1:0] sh_cnt,
    input  logic [1:0]                op_sel,
    output logic [DATA_W-1:0]         result
);

    localparam int CNT_W = $clog2(DATA_W);

    shift_op_e    op;
    logic         go_left;
    logic         fill_bit;
    logic [DATA_W-1:0] a_rev;
    logic [DATA_W-1:0] net_in;
    logic [DATA_W-1:0] net_out;
    logic [DATA_W-1:0] out_rev;

    assign op = shift_op_e'(op_sel);

    // Decode of the select into datapath controls
    always_comb begin
        go_left  = 1'b0;
        fill_bit = 1'b0;
        unique case (op)
            SHL_ZERO: go_left  = 1'b1;
            SHR_SIGN: fill_bit = opnd_a[DATA_W-1];
            SHR_ZERO,
            PASS:     ;
        endcase
    end

    alu_shift_bitrev #(.W(DATA_W)) u_rev_in (
        .din  (opnd_a),
        .dout (a_rev)
    );

    assign net_in = go_left ? a_rev : opnd_a;

    alu_shift_barrel #(
        .W     (DATA_W),
        .CNT_W (CNT_W)
    ) u_barrel (
        .din  (net_in),
        .cnt  (sh_cnt),
        .fill (fill_bit),
        .dout (net_out)
    );

    alu_shift_bitrev #(.W(DATA_W)) u_rev_out (
        .din  (net_out),
        .dout (out_rev)
    );

    // Output selection
    always_comb begin
        unique case (op)
            SHL_ZERO: result = out_rev;
            PASS:     result = opnd_a;
            SHR_ZERO,
            SHR_SIGN: result = net_out;
        endcase
    end

endmodule

// File: rtl/alu_shift_unit_chk.sv
module alu_shift_unit_chk #(
    parameter int DATA_W = 32
) (
    input logic [DATA_W-1:0]         opnd_a,
    input logic [$clog2(DATA_W)-1:0] sh_cnt,
    input logic [1:0]                op_sel,
    input logic [DATA_W-1:0]         result
);

    always_comb begin
        if (sh_cnt == '0) begin
            p_zero_count_identity_r1: assert (result == opnd_a)
                else $error("zero count altered operand");
        end
        if (op_sel == 2'b00 && sh_cnt != '0) begin
            p_left_low_bit_clear_r2: assert (result[0] == 1'b0)
                else $error("left shift left low bit set");
        end
        if (op_sel == 2'b10 && sh_cnt != '0) begin
            p_right_top_bit_clear_r3: assert (result[DATA_W-1] == 1'b0)
                else $error("zero-fill right shift set top bit");
        end
        if (op_sel == 2'b11) begin
            p_sign_kept_r4: assert (result[DATA_W-1] == opnd_a[DATA_W-1])
                else $error("sign-fill right shift lost sign");
        end
        if (op_sel == 2'b01) begin
            p_pass_code_r6: assert (result == opnd_a)
                else $error("pass code changed operand");
        end
    end

endmodule

bind alu_shift_unit alu_shift_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .opnd_a (opnd_a),
    .sh_cnt (sh_cnt),
    .op_sel (op_sel),
    .result (result)
);

// File: tb/alu_shift_unit_tb.sv
`timescale 1ns/1ps
module alu_shift_unit_tb;

    logic        clk = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [4:0]  sh_cnt = '0;
    logic [1:0]  op_sel = '0;
    logic [31:0] result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    alu_shift_unit u_dut (
        .opnd_a (opnd_a),
        .sh_cnt (sh_cnt),
        .op_sel (op_sel),
        .result (result)
    );

    // {op(2), cnt(5), operand(32), expected(32)}
    localparam int NV = 16;
    localparam logic [70:0] VEC [0:NV-1] = '{
        {2'b11, 5'd31, 32'hFEDCBA98, 32'hFFFFFFFF},
        {2'b10, 5'd24, 32'hFEDCBA98, 32'h000000FE},
        {2'b00, 5'd4,  32'hFEDCBA98, 32'hEDCBA980},
        {2'b11, 5'd16, 32'hFEDCBA98, 32'hFFFFFEDC},
        {2'b00, 5'd0,  32'hFEDCBA98, 32'hFEDCBA98},
        {2'b10, 5'd0,  32'hFEDCBA98, 32'hFEDCBA98},
        {2'b11, 5'd0,  32'hFEDCBA98, 32'hFEDCBA98},
        {2'b00, 5'd31, 32'hFEDCBA98, 32'h00000000},
        {2'b10, 5'd31, 32'hFEDCBA98, 32'h00000001},
        {2'b11, 5'd8,  32'hFEDCBA98, 32'hFFFEDCBA},
        {2'b10, 5'd28, 32'hFEDCBA98, 32'h0000000F},
        {2'b00, 5'd16, 32'hFEDCBA98, 32'hBA980000},
        {2'b11, 5'd12, 32'h7EDCBA98, 32'h0007EDCB},
        {2'b10, 5'd12, 32'h7EDCBA98, 32'h0007EDCB},
        {2'b01, 5'd9,  32'hFEDCBA98, 32'hFEDCBA98},
        {2'b01, 5'd31, 32'h12345678, 32'h12345678}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h cnt=%0d op=%b got=%h exp=%h",
                     tag, opnd_a, sh_cnt, op_sel, got, exp);
        end
    endtask

    function automatic logic [31:0] ref_shift(input logic [31:0] a, input logic [4:0] c,
                                              input logic [1:0] op);
        case (op)
            2'b00:   return a << c;
            2'b10:   return a >> c;
            2'b11:   return $unsigned($signed(a) >>> c);
            default: return a;
        endcase
    endfunction

    task automatic apply(input logic [31:0] a, input logic [4:0] c, input logic [1:0] op);
        @(negedge clk);
        opnd_a = a;
        sh_cnt = c;
        op_sel = op;
        #1;
    endtask

    initial begin
        logic [31:0] srl_v;
        // Zero operand at start: result must be zero for every shift select
        apply(32'h0, 5'd0, 2'b00);
        check("R1 zero operand start", result, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][63:32], VEC[i][68:64], VEC[i][70:69]);
            case (VEC[i][70:69])
                2'b00:   check(VEC[i][68:64] == 0 ? "R1 table" : "R2 table", result, VEC[i][31:0]);
                2'b10:   check(VEC[i][68:64] == 0 ? "R1 table" : "R3 table", result, VEC[i][31:0]);
                2'b11:   check(VEC[i][68:64] == 0 ? "R1 table" : "R4 table", result, VEC[i][31:0]);
                default: check("R6 table", result, VEC[i][31:0]);
            endcase
        end

        // Full sweep: negative and positive operand, all counts, all shifts
        for (int p = 0; p < 2; p++) begin
            for (int o = 0; o < 3; o++) begin
                for (int c = 0; c < 32; c++) begin
                    logic [31:0] a;
                    logic [1:0]  op;
                    a  = (p == 0) ? 32'hFEDCBA98 : 32'h7A5C3E19;
                    op = (o == 0) ? 2'b00 : ((o == 1) ? 2'b10 : 2'b11);
                    apply(a, c[4:0], op);
                    check("R8 sweep", result, ref_shift(a, c[4:0], op));
                end
            end
        end

        // R5: positive operand, sign fill equals zero fill
        for (int c = 0; c < 32; c += 3) begin
            apply(32'h5A3C0FF1, c[4:0], 2'b10);
            srl_v = result;
            apply(32'h5A3C0FF1, c[4:0], 2'b11);
            check("R5 positive sra==srl", result, srl_v);
        end

        // R6: pass code over several counts
        for (int c = 1; c < 32; c += 7) begin
            apply(32'h8001C0DE, c[4:0], 2'b01);
            check("R6 pass code", result, 32'h8001C0DE);
        end

        // R7: inputs change between clock edges, result follows at once
        @(posedge clk);
        #0.5;
        opnd_a = 32'hF0000000;
        sh_cnt = 5'd4;
        op_sel = 2'b11;
        #0.1;
        check("R7 no clock needed", result, 32'hFF000000);
        op_sel = 2'b10;
        #0.1;
        check("R7 select change", result, 32'h0F000000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got=timeout exp=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule